// File: doc/BRIEF.md
# Nine-Word Register Bank with Masked-OR Readback

This block is a small bank of nine 16-bit registers hung on a simple host bus. The host writes a word by raising chip select and the write strobe with an address and write data, and reads a word by raising chip select and the read strobe. The addressed register loads on the rising clock edge.

Readback never uses a binary-indexed multiplexer or an internal high-impedance driver. The address and the read strobe are decoded into a one-hot select vector. Each register ANDs its contents with its own select bit, so every source that is not addressed gives all zeros. The nine masked words are then ORed together to form the read bus.

A parameter picks how the read path is built. In the default registered form, each source's masked word passes through a flip-flop whose synchronous clear is the inverse of its select, and read data appears one clock after the strobe is sampled. In the combinational form, the read data appears in the same cycle.

Top module: `regbank_andor`

## Requirements
- R1: After the synchronous reset `rst` is released, all nine registers hold zero and `rdData` is zero.
- R2: On a rising clock edge with `chipSel` and `wrStrobe` both high and `addr` in 0..8, the register at that address loads `wrData`.
- R3: A write cycle with `chipSel` low or `wrStrobe` low changes no register.
- R4: A write to an address in 9..15 changes no register.
- R5: The internal read select is one-hot or zero. Bit k is high only when `addr` equals k, `chipSel` is high and `rdStrobe` is high. A read returns exactly the addressed word, with no bits ORed in from other registers.
- R6: With the default registered read path, `rdData` equals the addressed register's contents one clock after the cycle in which `chipSel` and `rdStrobe` are sampled high.
- R7: A read at an address in 9..15 asserts no select bit and gives `rdData` of zero.
- R8: In the clock after any cycle in which `chipSel` or `rdStrobe` is low, `rdData` is zero.
- R9: When a read and a write hit the same address in the same cycle, `rdData` returns the contents from before that write. The new value is returned by the next read.
- R10: A write to one register leaves the other eight unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chipSel | input | 1 | Bank select, active high |
| rdStrobe | input | 1 | Read request, active high |
| wrStrobe | input | 1 | Write request, active high |
| addr | input | 4 | Register address; 0..8 are valid |
| wrData | input | 16 | Write data |
| rdData | output | 16 | OR of the masked register words |

## Verification
The assertions assume that the host holds `rst` high from time zero through at least the first clock edge. They also assume that the inputs are never unknown while reset is low. Beyond that, no protocol is assumed: chip select and both strobes may be high together, and any address may appear. The random stimulus therefore draws every input freely over the full 4-bit address space, including simultaneous read and write to the same address. Directed cases force the out-of-range addresses and the single-strobe combinations.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int BANK_REGS   = 9;
  localparam int BANK_WIDTH  = 16;
  localparam int BANK_ADDR_W = 4;

  // Qualified bus strobes handed from control to datapath
  typedef struct packed {
    logic wrFire;
    logic rdFire;
  } bankStrobe_t;

endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = BANK_REGS,
  parameter int ADDR_W   = BANK_ADDR_W
) (
  input  logic                chipSel,
  input  logic                rdStrobe,
  input  logic                wrStrobe,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] addrHit,
  output bankStrobe_t         strb
);

  // Address-only one-hot decode; out-of-range addresses match nothing
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(i);
    assign addrHit[i] = (addr == SLOT);
  end

  always_comb begin
    strb.wrFire = chipSel & wrStrobe;
    strb.rdFire = chipSel & rdStrobe;
  end

endmodule

// File: rtl/regbank_dpath.sv
module regbank_dpath
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = BANK_REGS,
  parameter int DATA_W   = BANK_WIDTH,
  parameter bit REG_READ = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  bankStrobe_t         strb,
  input  logic [NUM_REGS-1:0] addrHit,
  input  logic [DATA_W-1:0]   wrData,
  output logic [NUM_REGS-1:0] rdSel,
  output logic [DATA_W-1:0]   rdData
);

  logic [NUM_REGS-1:0] wrSel;
  logic [DATA_W-1:0]   regQ    [NUM_REGS];
  logic [DATA_W-1:0]   srcWord [NUM_REGS];

  assign wrSel = addrHit & {NUM_REGS{strb.wrFire}};
  assign rdSel = addrHit & {NUM_REGS{strb.rdFire}};

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)           regQ[i] <= '0;
      else if (wrSel[i]) regQ[i] <= wrData;
    end

    if (REG_READ) begin : g_flop
      // Clear whenever not addressed, so the source drives zeros
      always_ff @(posedge clk) begin
        if (rst || !rdSel[i]) srcWord[i] <= '0;
        else                  srcWord[i] <= regQ[i];
      end
    end else begin : g_mask
      assign srcWord[i] = regQ[i] & {DATA_W{rdSel[i]}};
    end
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_REGS; k++) rdData |= srcWord[k];
  end

endmodule

// File: rtl/regbank_andor.sv
module regbank_andor
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = BANK_REGS,
  parameter int DATA_W   = BANK_WIDTH,
  parameter int ADDR_W   = BANK_ADDR_W,
  parameter bit REG_READ = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chipSel,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [NUM_REGS-1:0] addrHit;
  logic [NUM_REGS-1:0] rdSel;
  bankStrobe_t         strb;

  regbank_ctrl #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) ctrl_i (
    .chipSel (chipSel),
    .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe),
    .addr    (addr),
    .addrHit (addrHit),
    .strb    (strb)
  );

  regbank_dpath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .REG_READ(REG_READ)) dpath_i (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .addrHit(addrHit),
    .wrData (wrData),
    .rdSel  (rdSel),
    .rdData (rdData)
  );

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int NUM_REGS = 9,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4,
  parameter bit REG_READ = 1'b1
) (
  input logic                clk,
  input logic                rst,
  input logic                chipSel,
  input logic                rdStrobe,
  input logic [ADDR_W-1:0]   addr,
  input logic [NUM_REGS-1:0] rdSel,
  input logic [DATA_W-1:0]   rdData
);

  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rdSel));

  assert_sel_gated_R5: assert property (@(posedge clk) disable iff (rst)
    !(chipSel && rdStrobe) |-> (rdSel == '0));

  assert_oob_nosel_R7: assert property (@(posedge clk) disable iff (rst)
    (int'(addr) >= NUM_REGS) |-> (rdSel == '0));

  if (REG_READ) begin : g_regd
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
      !(chipSel && rdStrobe) |=> (rdData == '0));
    assert_oob_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (chipSel && rdStrobe && int'(addr) >= NUM_REGS) |=> (rdData == '0));
  end else begin : g_comb
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
      !(chipSel && rdStrobe) |-> (rdData == '0));
    assert_oob_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (chipSel && rdStrobe && int'(addr) >= NUM_REGS) |-> (rdData == '0));
  end

endmodule

bind regbank_andor regbank_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_READ(REG_READ)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .chipSel (chipSel),
  .rdStrobe(rdStrobe),
  .addr    (addr),
  .rdSel   (rdSel),
  .rdData  (rdData)
);

// File: tb/regbank_andor_tb_top.sv
`timescale 1ns/1ps
module regbank_andor_tb_top;

  localparam int NREG = 9;
  localparam int DW   = 16;
  localparam int AW   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chipSel = 1'b0, rdStrobe = 1'b0, wrStrobe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;

  logic [DW-1:0] model [NREG];
  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  regbank_andor dut_i (
    .clk(clk), .rst(rst), .chipSel(chipSel), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected read word for one bus cycle, taken from the model before its write lands
  function automatic logic [DW-1:0] predict(input bit c, input bit r, input logic [AW-1:0] a);
    if (c && r && int'(a) < NREG) return model[a];
    return '0;
  endfunction

  // Called at a falling edge: drive one bus cycle, then check rdData a clock later
  task automatic step(input bit c, input bit r, input bit w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string req);
    logic [DW-1:0] expv;
    chipSel = c; rdStrobe = r; wrStrobe = w; addr = a; wrData = d;
    expv = predict(c, r, a);
    if (c && w && int'(a) < NREG) model[a] = d;
    @(negedge clk);
    check(req, rdData, expv);
  endtask

  task automatic readAll(input string req);
    for (int k = 0; k < NREG; k++) step(1, 1, 0, AW'(k), 16'h0, req);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    for (int k = 0; k < NREG; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", rdData, 16'h0);
    readAll("R1");

    // R2/R10: distinct words, each register read back on its own
    for (int k = 0; k < NREG; k++) step(1, 0, 1, AW'(k), 16'h1 << k, "R2");
    readAll("R10");
    // R5: single-bit words show that no neighbour leaks into the OR
    step(1, 1, 0, 4'd4, 16'h0, "R5");
    step(1, 1, 0, 4'd8, 16'h0, "R5");

    // R3: write without chip select, then without write strobe
    step(0, 0, 1, 4'd2, 16'hDEAD, "R3");
    step(1, 0, 0, 4'd2, 16'hBEEF, "R3");
    step(1, 1, 0, 4'd2, 16'h0, "R3");

    // R4: writes to 9..15 leave every register alone
    for (int a = NREG; a < 16; a++) step(1, 0, 1, AW'(a), 16'hFFFF, "R4");
    readAll("R4");

    // R7: reads of 9..15 give zero
    for (int a = NREG; a < 16; a++) step(1, 1, 0, AW'(a), 16'h0, "R7");

    // R8: a partial read strobe returns zero although the register is nonzero
    step(0, 1, 0, 4'd3, 16'h0, "R8");
    step(1, 0, 0, 4'd3, 16'h0, "R8");

    // R9: read and write of the same address in one cycle
    step(1, 1, 1, 4'd6, 16'hA5A5, "R9");
    step(1, 1, 0, 4'd6, 16'h0, "R9");

    // R6: free random traffic over the whole address space
    for (int n = 0; n < 600; n++) begin
      logic [31:0] rv;
      rv = $urandom();
      step(rv[0] | rv[1], rv[2], rv[3], rv[7:4], 16'($urandom()), "R6");
    end
    readAll("R6");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule